// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the frequency of a clock that is unrelated to the system clock. It counts cycles of the measured clock over a gate interval. Each gate boundary closes one interval: the count is stored as the result and the counter starts again from zero. The gate boundaries come from one of two places, chosen at build time. The first is an internal timebase that runs on the system clock and fires once every `SYS_HZ` system cycles, which gives a one-second gate when `SYS_HZ` is the system clock rate in hertz. The second is an external one-cycle strobe that arrives once per second in the system clock domain.

The gate event reaches the measured-clock domain through a toggle synchronizer. The finished count goes back to the system domain as a whole word, qualified by a second toggle synchronizer. A one-cycle valid strobe in the system domain marks each new result. With `SYNC_OUT` set, the result is also registered in the system domain. When the measured clock runs too fast for `CNT_W` bits, the count stops at all-ones instead of wrapping. The interval that is open when reset is released is always partial, so it is discarded.

Top module: `clkfreq_meter`

## Requirements
- R1: Each result equals the number of rising edges of `meas_clk` between two consecutive gate boundaries as seen in the measured domain. The boundary cycle belongs to the interval it closes, and the counter is zero in the cycle that follows a boundary.
- R2: With `GATE_SRC` = `GATE_TIMEBASE`, a gate boundary occurs once every `SYS_HZ` `sys_clk` cycles, and `pps_in` is ignored.
- R3: The counter saturates at 2^`CNT_W`-1 and never wraps. A result that would exceed this value reads as all-ones.
- R4: With `GATE_SRC` = `GATE_PPS`, each one-cycle high pulse on `pps_in` is one gate boundary.
- R5: `freq_valid` is high for exactly one `sys_clk` cycle per result, and in steady state results arrive once per gate interval.
- R6: While `rst_n` is low, `freq_out` reads 0 and `freq_valid` reads 0. The first boundary after reset only starts counting, so the first result covers one complete gate interval.
- R7: With `SYNC_OUT` = 1, `freq_out` is a `sys_clk` register that changes only in a cycle where `freq_valid` is high.
- R8: With `SYNC_OUT` = 0, `freq_out` is the result register in the measured domain. It is stable whenever `freq_valid` is high, and it carries the same value that the synchronized variant would show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; timebase, gate strobe and result strobe domain |
| meas_clk | input | 1 | Clock under measurement |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| pps_in | input | 1 | External one-cycle gate strobe (system domain), used in PPS mode |
| freq_out | output | CNT_W | Latest count of measured-clock cycles per gate interval |
| freq_valid | output | 1 | One-cycle strobe in the system domain marking a new result |

## Verification
The embedded assertions check these rules on every cycle: the counter restarts after a boundary, the count holds at all-ones once it saturates, the internal gate ticks are isolated one-cycle events, the valid strobe is one cycle wide, and the synchronized output changes only together with the strobe. Other behaviour can only be shown by the bench's scenarios. These are the exact count for each ratio of measured clock to system clock, saturation of a narrow counter, the external strobe mode, and the spacing of results. They also include discarding the partial first interval, which the bench checks through the value and the arrival time of the first result after reset.

// File: rtl/clkfreq_pkg.sv
// Package: shared types of the gated clock frequency meter.
package clkfreq_pkg;
    // Source of the gate boundaries.
    typedef enum logic {
        GATE_TIMEBASE = 1'b0,   // internal divider on the system clock
        GATE_PPS      = 1'b1    // external one-cycle strobe
    } gate_src_e;
endpackage

// File: rtl/clkfreq_gate_gen.sv
// Gate generator (system clock domain).
// Emits a one-cycle gate tick per interval. In timebase mode a divider counts
// SYS_HZ cycles. In PPS mode the external strobe is passed through unchanged.
// Assumes: SYS_HZ >= 2; the external strobe is synchronous to sys_clk and one
// cycle wide.
module clkfreq_gate_gen
    import clkfreq_pkg::*;
#(
    parameter gate_src_e GATE_SRC = GATE_TIMEBASE,
    parameter int        SYS_HZ   = 125_000_000
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic pps_in,
    output logic gate_tick
);
    localparam int DIV_W = $clog2(SYS_HZ);

    generate
        if (GATE_SRC == GATE_TIMEBASE) begin : g_timebase
            logic [DIV_W-1:0] div_q;
            logic             last_c;
            logic             unused_pps;

            assign unused_pps = pps_in;
            assign last_c     = (div_q == DIV_W'(SYS_HZ - 1));
            assign gate_tick  = last_c;

            // Purpose: free-running divider that wraps after SYS_HZ cycles.
            always_ff @(posedge sys_clk) begin
                if (!rst_n) div_q <= '0;
                else if (last_c) div_q <= '0;
                else div_q <= div_q + 1'b1;
            end

            // R2: a tick is never followed by another tick in the next cycle
            p_tick_isolated_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
                gate_tick |=> !gate_tick);
        end else begin : g_pps
            assign gate_tick = pps_in;
        end
    endgenerate
endmodule

// File: rtl/clkfreq_toggle_sync.sv
// Toggle synchronizer for single-cycle events.
// A source pulse flips a level register. The level passes through two
// destination flops, and a third flop detects its edge, so each source event
// becomes exactly one destination pulse.
// Assumes: source events are spaced by more than three destination cycles.
module clkfreq_toggle_sync (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);
    logic       tog_q;
    logic [2:0] dsync_q;

    // Purpose: flip the level once per source event.
    always_ff @(posedge src_clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else if (src_pulse) tog_q <= ~tog_q;
    end

    // Purpose: two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) dsync_q <= '0;
        else dsync_q <= {dsync_q[1:0], tog_q};
    end

    assign dst_pulse = dsync_q[1] ^ dsync_q[2];

    // R5: every crossed event is a single destination cycle
    p_single_event_r5: assert property (@(posedge dst_clk) disable iff (!rst_n)
        dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/clkfreq_counter.sv
// Measured-clock cycle counter with result latch.
// Counts every meas_clk cycle and saturates at all-ones. At a gate boundary
// it stores the count (the boundary cycle included) and restarts from zero.
// The first boundary after reset only arms the counter.
// Assumes: gate_evt is a one-cycle pulse in the meas_clk domain.
module clkfreq_counter #(
    parameter int CNT_W = 32
) (
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic             gate_evt,
    output logic [CNT_W-1:0] result,
    output logic             result_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             armed_q;

    assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    // Purpose: count, close the interval at a boundary, and publish the result.
    always_ff @(posedge meas_clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            result     <= '0;
            armed_q    <= 1'b0;
            result_evt <= 1'b0;
        end else if (gate_evt) begin
            cnt_q      <= '0;
            armed_q    <= 1'b1;
            result_evt <= armed_q;
            if (armed_q) result <= cnt_inc;
        end else begin
            cnt_q      <= cnt_inc;
            result_evt <= 1'b0;
        end
    end

    // R1: the counter is zero right after a boundary
    p_restart_r1: assert property (@(posedge meas_clk) disable iff (!rst_n)
        gate_evt |=> (cnt_q == '0));

    // R3: once at all-ones, the count holds until the next boundary
    p_no_overflow_r3: assert property (@(posedge meas_clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && !gate_evt |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/clkfreq_meter.sv
// Gated clock frequency meter, top level.
// The gate source is chosen by GATE_SRC. Gate ticks cross into the measured
// domain, and the finished count crosses back as a whole word. The word is
// held stable for a full interval and is sampled only after its qualifier
// has been synchronized.
// Assumes: rst_n is synchronous and held for several cycles of both clocks;
// the gate interval is much longer than the synchronizer latency.
module clkfreq_meter
    import clkfreq_pkg::*;
#(
    parameter int        CNT_W    = 32,
    parameter int        SYS_HZ   = 125_000_000,
    parameter gate_src_e GATE_SRC = GATE_TIMEBASE,
    parameter bit        SYNC_OUT = 1'b1
) (
    input  logic             sys_clk,
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic             pps_in,
    output logic [CNT_W-1:0] freq_out,
    output logic             freq_valid
);
    logic             gate_sys;
    logic             gate_meas;
    logic [CNT_W-1:0] res_meas;
    logic             res_evt_meas;
    logic             res_evt_sys;
    logic             valid_q;

    clkfreq_gate_gen #(.GATE_SRC(GATE_SRC), .SYS_HZ(SYS_HZ)) u_gate (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .pps_in   (pps_in),
        .gate_tick(gate_sys)
    );

    clkfreq_toggle_sync u_gate_xing (
        .src_clk  (sys_clk),
        .dst_clk  (meas_clk),
        .rst_n    (rst_n),
        .src_pulse(gate_sys),
        .dst_pulse(gate_meas)
    );

    clkfreq_counter #(.CNT_W(CNT_W)) u_count (
        .meas_clk  (meas_clk),
        .rst_n     (rst_n),
        .gate_evt  (gate_meas),
        .result    (res_meas),
        .result_evt(res_evt_meas)
    );

    clkfreq_toggle_sync u_res_xing (
        .src_clk  (meas_clk),
        .dst_clk  (sys_clk),
        .rst_n    (rst_n),
        .src_pulse(res_evt_meas),
        .dst_pulse(res_evt_sys)
    );

    // Purpose: one-cycle result strobe in the system domain.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else valid_q <= res_evt_sys;
    end
    assign freq_valid = valid_q;

    generate
        if (SYNC_OUT) begin : g_sync_out
            logic [CNT_W-1:0] freq_q;

            // Purpose: capture the stable measured-domain word on its qualifier.
            always_ff @(posedge sys_clk) begin
                if (!rst_n) freq_q <= '0;
                else if (res_evt_sys) freq_q <= res_meas;
            end
            assign freq_out = freq_q;

            // R7: the registered result moves only with the valid strobe
            p_out_with_valid_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
                !$stable(freq_out) |-> freq_valid);
        end else begin : g_raw_out
            assign freq_out = res_meas;
        end
    endgenerate

    // R5: the valid strobe lasts one system cycle
    p_valid_pulse_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        freq_valid |=> !freq_valid);
endmodule

// File: tb/tb_clkfreq_meter.sv
`timescale 1ns/1ps
module tb_clkfreq_meter;
    import clkfreq_pkg::*;

    localparam int W_A    = 16;
    localparam int W_B    = 6;
    localparam int HZ_A   = 150;   // timebase gate: 150 sys cycles = 1200 ns
    localparam int PPS_IV = 120;   // external gate: 120 sys cycles = 960 ns

    logic sys_clk  = 1'b0;
    logic meas_clk = 1'b0;
    logic rst_n    = 1'b0;
    logic pps_in   = 1'b0;
    logic [W_A-1:0] freq_a;
    logic [W_B-1:0] freq_b;
    logic valid_a, valid_b;

    int  checks = 0;
    int  fails  = 0;
    int  px2    = 40;          // measured period times two, in ns
    real meas_half = 10.0;
    int  change_id = 0;
    int  good_a = 0;
    int  good_b = 0;
    int  cyc = 0;

    // DUT A: internal timebase, synchronized output, wide counter.
    clkfreq_meter #(.CNT_W(W_A), .SYS_HZ(HZ_A), .GATE_SRC(GATE_TIMEBASE), .SYNC_OUT(1'b1)) dut (
        .sys_clk(sys_clk), .meas_clk(meas_clk), .rst_n(rst_n), .pps_in(pps_in),
        .freq_out(freq_a), .freq_valid(valid_a));

    // DUT B: external strobe, raw output, narrow counter that saturates.
    clkfreq_meter #(.CNT_W(W_B), .SYS_HZ(HZ_A), .GATE_SRC(GATE_PPS), .SYNC_OUT(1'b0)) dut_x (
        .sys_clk(sys_clk), .meas_clk(meas_clk), .rst_n(rst_n), .pps_in(pps_in),
        .freq_out(freq_b), .freq_valid(valid_b));

    always #4 sys_clk = ~sys_clk;            // 125 MHz
    initial forever #(meas_half) meas_clk = ~meas_clk;

    function automatic int exp_count(int window_ns, int p2, int width);
        int raw;
        int top;
        raw = (window_ns * 2) / p2;
        top = (1 << width) - 1;
        return (raw > top) ? top : raw;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // External gate strobe: one cycle high every PPS_IV sys cycles (R4).
    initial begin
        wait (rst_n);
        forever begin
            repeat (PPS_IV - 1) @(negedge sys_clk);
            pps_in = 1'b1;
            @(negedge sys_clk);
            pps_in = 1'b0;
        end
    end

    // Monitor, sampled at the falling sys edge.
    int  seen_a = 0, seen_b = 0, skip_a = 0, skip_b = 0;
    int  first_a = -1, first_b = -1, last_a = 0;
    bit  prev_ok_a = 1'b0;
    always @(negedge sys_clk) begin
        if (rst_n) begin
            cyc++;
            if (seen_a != change_id) begin seen_a = change_id; skip_a = 2; prev_ok_a = 1'b0; end
            if (seen_b != change_id) begin seen_b = change_id; skip_b = 2; end
            if (valid_a) begin
                if (first_a < 0) begin
                    first_a = cyc;
                    // R6: the first result needs two timebase boundaries
                    check("R6 first result delay A", (cyc >= 2 * HZ_A) ? 1 : 0, 1);
                end
                if (skip_a > 0) begin
                    skip_a--;
                    prev_ok_a = 1'b0;
                end else begin
                    // R1/R2: exact count over a SYS_HZ-cycle window
                    check("R1 R2 count A", int'(freq_a), exp_count(HZ_A * 8, px2, W_A));
                    // R5: one result per gate interval
                    if (prev_ok_a) check("R5 result spacing A", cyc - last_a, HZ_A);
                    prev_ok_a = 1'b1;
                    good_a++;
                end
                last_a = cyc;
            end
            if (valid_b) begin
                if (first_b < 0) begin
                    first_b = cyc;
                    check("R6 first result delay B", (cyc >= 2 * PPS_IV) ? 1 : 0, 1);
                end
                if (skip_b > 0) skip_b--;
                else begin
                    // R3/R4/R8: strobe-gated count, saturating, raw output
                    check("R3 R4 R8 count B", int'(freq_b), exp_count(PPS_IV * 8, px2, W_B));
                    good_b++;
                end
            end
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge sys_clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic run_period(int p2, int n);
        int base;
        px2 = p2;
        meas_half = p2 / 4.0;
        change_id++;
        base = good_a;
        while (good_a < base + n) @(negedge sys_clk);
    endtask

    localparam int NP = 9;
    int p2_tab [NP] = '{8, 12, 16, 20, 24, 30, 40, 48, 60};

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        repeat (20) @(negedge sys_clk);
        // R6: outputs are cleared under reset
        check("R6 reset freq A", int'(freq_a), 0);
        check("R6 reset valid A", int'(valid_a), 0);
        check("R6 reset freq B", int'(freq_b), 0);
        check("R6 reset valid B", int'(valid_b), 0);
        rst_n = 1'b1;
        // First results at 20 ns period, taken directly after reset (R6).
        while (good_a < 2) @(negedge sys_clk);
        // Directed corners: fastest clock (B saturates, R3) and slowest.
        run_period(8, 3);
        run_period(60, 3);
        run_period(30, 3);   // 960/15 = 64 -> saturates to 63 (R3)
        // Random mix of ratios with a fixed seed.
        for (int i = 0; i < 8; i++) begin
            run_period(p2_tab[$urandom % NP], 3);
        end
        check("R4 external results seen", (good_b > 10) ? 1 : 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule